// File: doc/BRIEF.md
# GPIO Input Capture and Interrupt Detector

This block samples the external levels of a 16-pin general purpose port, stores the accepted levels as the port's captured input data, and raises one interrupt request per pin. Each pin has five control bits. The direction bit and the input-enable bit together decide whether the pin is listened to at all. The trigger-mode bit and the both-edges bit select a level trigger, a single-edge trigger or an any-edge trigger. The polarity bit sets which level counts as active, or which single edge counts.

Pin levels are asynchronous, so they first pass a two-flop synchroniser. A capture stage then compares the synchronised level with the level stored last time and updates the stored level. Every pin is handled on its own, in parallel, on every clock. The register interface that owns the control vectors, and the interrupt controller that consumes the requests, sit outside this block.

Top module: `gpcap_detector`

## Requirements
- R1: After a clock edge with `rst_n` low, every bit of `data_o` and `irq_o` is 0.
- R2: A pin whose `dir_i` bit is 1 (output) is ignored. Its `data_o` bit keeps its value. In level mode its `irq_o` bit keeps its value, and in either edge mode its `irq_o` bit is 0.
- R3: A pin whose `in_en_i` bit is 0 is ignored in the same way as in R2.
- R4: For an accepted pin (`dir_i`=0, `in_en_i`=1), a level change on `pin_i` appears on `data_o` after the third rising clock edge following the change: two synchroniser flops and then the capture flop.
- R5: In level mode (`edge_mode_i` bit = 0), an accepted pin's `irq_o` bit is updated on the same edge as its `data_o` bit. It becomes 1 when the captured level differs from the `polar_i` bit and 0 when the two are equal. A polarity of 0 therefore makes a high level active, and a polarity of 1 makes a low level active.
- R6: In single-edge mode (`edge_mode_i`=1, `both_edges_i`=0), an accepted pin raises `irq_o` when its stored level goes from 0 to 1 with `polar_i`=0, or from 1 to 0 with `polar_i`=1. The opposite edge raises nothing.
- R7: In any-edge mode (`edge_mode_i`=1, `both_edges_i`=1), every change of an accepted pin's stored level raises `irq_o`.
- R8: In both edge modes, each detected edge produces an `irq_o` pulse exactly one clock cycle wide, appearing together with the `data_o` change. The pulse ends on the next edge even if the pin becomes ignored in that cycle.
- R9: Pins are independent: one pin's controls and level never affect another pin's `data_o` or `irq_o` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 16 | Asynchronous pin levels |
| dir_i | input | 16 | Per-pin direction, 1 = output (ignored) |
| in_en_i | input | 16 | Per-pin input enable, 1 = listen |
| polar_i | input | 16 | Per-pin polarity: active-low level or falling edge when 1 |
| edge_mode_i | input | 16 | Per-pin trigger mode, 1 = edge, 0 = level |
| both_edges_i | input | 16 | Per-pin any-edge select, used in edge mode |
| data_o | output | 16 | Captured input levels |
| irq_o | output | 16 | Per-pin interrupt requests |

## Verification
A wrong stored level is visible on `data_o` right away. It also shows up on `irq_o` on the next transition, as a missing edge pulse or a spurious one, or on the next edge as a level request with the wrong value. A synchroniser stage that is missing or added moves the `data_o` change one cycle away from the third edge, and a per-cycle comparison against an independent model catches that within that cycle. An edge pulse that sticks is caught one cycle after it should have dropped.

// File: rtl/gpcap_pkg.sv
// gpcap_pkg: types shared by the input capture and interrupt detector.
// Assumes: nothing beyond the standard language.
package gpcap_pkg;

    // Trigger kinds a pin can be configured for
    typedef enum logic [1:0] {
        TRIG_LEVEL    = 2'd0,
        TRIG_ONE_EDGE = 2'd1,
        TRIG_ANY_EDGE = 2'd2
    } trig_e;

    // Map the two mode control bits onto a trigger kind
    function automatic trig_e decode_trig(input logic edge_mode, input logic both_edges);
        if (!edge_mode)
            return TRIG_LEVEL;
        else if (both_edges)
            return TRIG_ANY_EDGE;
        else
            return TRIG_ONE_EDGE;
    endfunction

endpackage

// File: rtl/gpcap_sync.sv
// gpcap_sync: multi-flop synchroniser for a vector of asynchronous pin levels.
// Assumes: every bit is independent, so no bus coherence is required.
// All stages reset to 0.
module gpcap_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the sampled levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[LAST];

    generate
        if (STAGES == 2) begin : g_chk2
            // R4: the output is the input from two edges earlier
            p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n && $past(rst_n) |=> sync_o == $past(async_i, 2));
        end
    endgenerate

endmodule

// File: rtl/gpcap_bit.sv
// gpcap_bit: capture flop and interrupt condition logic for one pin.
// Assumes: pin_s is already synchronised to clk, and the control bits are
// quasi-static register outputs in the same clock domain.
module gpcap_bit
    import gpcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic dir_out,
    input  logic in_en,
    input  logic polar,
    input  logic edge_mode,
    input  logic both_edges,
    output logic data_o,
    output logic irq_o
);

    logic  accepted;
    logic  data_q;
    logic  irq_q;
    logic  rise;
    logic  fall;
    logic  edge_hit;
    trig_e trig;

    // A pin is listened to only as an enabled input
    assign accepted = !dir_out && in_en;
    assign rise     = !data_q && pin_s;
    assign fall     = data_q && !pin_s;

    // Decode the trigger kind from the mode bits
    always_comb trig = decode_trig(edge_mode, both_edges);

    // Select the transition that counts for the chosen edge mode
    always_comb begin
        case (trig)
            TRIG_ANY_EDGE: edge_hit = rise || fall;
            TRIG_ONE_EDGE: edge_hit = polar ? fall : rise;
            default:       edge_hit = 1'b0;
        endcase
    end

    // Store the new level of an accepted pin, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= 1'b0;
        else if (accepted)
            data_q <= pin_s;
    end

    // Level requests track the level; edge requests last one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (trig == TRIG_LEVEL)
            irq_q <= accepted ? (pin_s != polar) : irq_q;
        else
            irq_q <= accepted && edge_hit;
    end

    assign data_o = data_q;
    assign irq_o  = irq_q;

    // R2: an ignored pin keeps its captured level
    p_ignored_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !accepted |=> $stable(data_q));

    // R3: an ignored pin in edge mode raises no request
    p_ignored_noirq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !accepted && edge_mode |=> !irq_q);

    // R5: a level request agrees with the stored level and the polarity
    p_level_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !edge_mode && accepted |=> irq_q == (data_q != $past(polar)));

    // R8: an edge request appears only with a change of the stored level
    p_edge_needs_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && edge_mode |=> !irq_q || (data_q != $past(data_q)));

endmodule

// File: rtl/gpcap_detector.sv
// gpcap_detector: per-pin input capture and interrupt detection for a port.
// Assumes: pin levels are asynchronous. The control vectors come from a
// register block in the clk domain.
module gpcap_detector #(
    parameter int NUM_PINS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] dir_i,
    input  logic [NUM_PINS-1:0] in_en_i,
    input  logic [NUM_PINS-1:0] polar_i,
    input  logic [NUM_PINS-1:0] edge_mode_i,
    input  logic [NUM_PINS-1:0] both_edges_i,
    output logic [NUM_PINS-1:0] data_o,
    output logic [NUM_PINS-1:0] irq_o
);

    logic [NUM_PINS-1:0] pin_sync;

    // Bring the pin levels into the clock domain
    gpcap_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    // One independent capture-and-detect slice per pin
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            gpcap_bit u_bit (
                .clk        (clk),
                .rst_n      (rst_n),
                .pin_s      (pin_sync[p]),
                .dir_out    (dir_i[p]),
                .in_en      (in_en_i[p]),
                .polar      (polar_i[p]),
                .edge_mode  (edge_mode_i[p]),
                .both_edges (both_edges_i[p]),
                .data_o     (data_o[p]),
                .irq_o      (irq_o[p])
            );
        end
    endgenerate

    // R1: outputs are clear after a reset edge
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (data_o == '0) && (irq_o == '0));

endmodule

// File: tb/gpcap_detector_bench.sv
`timescale 1ns/1ps
module gpcap_detector_bench;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '0, dir = '0, inen = '0, polar = '0, emode = '0, both = '0;
    logic [N-1:0] data_o, irq_o;

    // Model state
    logic [N-1:0] m1 = '0, m2 = '0, md = '0, mirq = '0;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    string phase = "R9";

    always #2 clk = ~clk;

    gpcap_detector u_gpcap_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin),
        .dir_i        (dir),
        .in_en_i      (inen),
        .polar_i      (polar),
        .edge_mode_i  (emode),
        .both_edges_i (both),
        .data_o       (data_o),
        .irq_o        (irq_o)
    );

    function automatic logic [N-1:0] next_data(input logic [N-1:0] s, d);
        logic [N-1:0] acc = ~dir & inen;
        return (acc & s) | (~acc & d);
    endfunction

    function automatic logic [N-1:0] next_irq(input logic [N-1:0] s, d, q);
        logic [N-1:0] acc  = ~dir & inen;
        logic [N-1:0] up   = ~d & s;
        logic [N-1:0] down = d & ~s;
        logic [N-1:0] hit  = (both & (up | down)) | (~both & ((polar & down) | (~polar & up)));
        logic [N-1:0] lvl  = ~emode & ((acc & (s ^ polar)) | (~acc & q));
        return lvl | (emode & acc & hit);
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one clock with the model, then compare at the falling edge
    task automatic tick();
        logic [N-1:0] nd, nq;
        if (!rst_n) begin
            nd = '0; nq = '0;
            m2 = '0; m1 = '0;
        end else begin
            nd = next_data(m2, md);
            nq = next_irq(m2, md, mirq);
            m2 = m1; m1 = pin;
        end
        @(posedge clk);
        md = nd; mirq = nq;
        @(negedge clk);
        chk({phase, " data"}, data_o, md);
        chk({phase, " irq"},  irq_o,  mirq);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        phase = "R1";
        repeat (3) tick();
        chk("R1 data reset", data_o, '0);
        chk("R1 irq reset", irq_o, '0);
        rst_n = 1'b1;

        // R4 and R5: latency and active-high level
        phase = "R4"; inen = '1; dir = '0; emode = '0; polar = '0; pin = '0;
        repeat (4) tick();
        pin = 16'hFFFF;
        tick(); chk("R4 edge1", data_o, 16'h0000);
        tick(); chk("R4 edge2", data_o, 16'h0000);
        tick(); chk("R4 edge3", data_o, 16'hFFFF);
        chk("R5 active high", irq_o, 16'hFFFF);
        phase = "R5"; polar = 16'hFFFF;
        tick(); chk("R5 active low idle", irq_o, 16'h0000);
        pin = 16'h00F0; repeat (3) tick();
        chk("R5 active low assert", irq_o, 16'hFF0F);

        // R6 and R8: rising pulse on pin0 lasts one cycle
        phase = "R6"; emode = '1; both = '0; polar = '0; pin = '0;
        repeat (5) tick();
        pin = 16'h0001;
        tick(); tick(); chk("R6 before", irq_o, 16'h0000);
        tick(); chk("R6 rising pulse", irq_o, 16'h0001);
        tick(); chk("R8 pulse ends", irq_o, 16'h0000);
        polar = 16'h0001; pin = 16'h0000;
        repeat (2) tick();
        dir = 16'h0000; tick(); chk("R6 falling pulse", irq_o, 16'h0001);
        inen = 16'hFFFE; tick(); chk("R8 ends while ignored", irq_o, 16'h0000);
        inen = '1;

        // R7: any-edge, toggling pins
        phase = "R7"; both = '1;
        for (int i = 0; i < 40; i++) begin pin = $urandom; tick(); end

        // R2: outputs ignored, pins toggling
        phase = "R2"; dir = '1;
        for (int i = 0; i < 40; i++) begin pin = $urandom; emode = $urandom; tick(); end
        dir = '0;

        // R3: inputs disabled, pins toggling
        phase = "R3"; inen = '0;
        for (int i = 0; i < 40; i++) begin pin = $urandom; emode = $urandom; tick(); end
        inen = '1;

        // R9: random mix, independent pins
        phase = "R9";
        for (int i = 0; i < 3000; i++) begin
            if (i % 16 == 0) begin
                dir = $urandom & $urandom; inen = $urandom | $urandom;
                polar = $urandom; emode = $urandom; both = $urandom;
            end
            pin = $urandom;
            tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule